// File: doc/BRIEF.md
# Statistical Operation Sampling Engine

This block watches a stream of issued operations and picks one out of every programmed interval for detailed profiling. A down-counter counts issued operations. When it expires, the operation issued in that cycle is selected, and its PC and operation class are latched. The block then tracks that operation until a completion port reports the same identifier. Between selection and completion it measures the access latency in clock cycles. The interval reload can be perturbed by a free-running pseudo-random generator, so that sampling does not lock onto loops in the program.

At completion the sample is checked against three filters: the operation class, two event-bit filters (one for bits that must be set, one for bits that must be clear) and a minimum latency. A sample that passes is written as a fixed four-beat record through a valid/ready write port. Writes go to a buffer pointer that software loads and that advances by one beat per handshake. A record whose end would pass the limit address is not written. Instead a sticky full flag and a service interrupt are raised, and qualifying samples are dropped until software clears the flag.

Top module: `op_sampler`

## Requirements
- R1: With jitter off, the operation selected is the P-th issued operation after sampling is enabled or after the previous selection, where P is the larger of `cfg_interval` and `MIN_INTERVAL`. All issued operations count toward P, whatever their level or class.
- R2: With `cfg_jitter` set, each reload after a selection is P XOR the low `JIT_W` bits of a 16-bit LFSR (taps 16, 14, 13, 11). The period therefore lies between P with its low `JIT_W` bits cleared and P with those bits set.
- R3: A record is four 64-bit beats at consecutive 8-byte addresses, starting at the buffer pointer:
  - beat 0 is the PC;
  - beat 1 is the data virtual address;
  - beat 2 is the physical address;
  - beat 3 is {timestamp[63:32], source[31:24], latency[23:8], zero[7:5], class[4:0]};
  - `wr_last` marks beat 3, and the pointer advances by 32 over the record.
- R4: With `cfg_ts_en` low, the timestamp field is zero. With `cfg_pa_en` low, beat 2 is zero.
- R5: A selected operation whose level is disabled (`op_kernel` high needs `cfg_kern_en`; `op_kernel` low needs `cfg_user_en`) is not tracked and produces no record.
- R6: `op_cls` is one-hot, with bit 0 branch, bit 1 load, bit 2 store, bit 3 SIMD and bit 4 floating point. A sample is kept only if `cfg_cls_mask` is zero or shares a bit with its class.
- R7: A sample is kept only if every bit of `cfg_evt_req` is set in `cmp_events` and no bit of `cfg_evt_forbid` is set in it.
- R8: The latency is the number of clock edges strictly between the selection edge and the completion edge, saturating at 2^LAT_W-1. A sample whose latency is below `cfg_min_lat` is discarded.
- R9: A level-enabled selection that occurs while a sample is still tracked or being written starts no new sample and increments `collisions` by one.
- R10: A passing sample whose record would end beyond `buf_limit` (pointer+32 > limit) is not written. It sets `buf_full` and `svc_irq`. Later samples are dropped, and the pointer does not move, until `full_clr` is pulsed.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_last` hold steady.
- R12: A completion whose identifier differs from the tracked one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sampling enable; while low the interval counter holds the base period |
| cfg_interval | input | CNT_W | Programmed sampling period in operations |
| cfg_jitter | input | 1 | Enables pseudo-random perturbation of the reload |
| cfg_cls_mask | input | 5 | Operation class filter (zero passes all) |
| cfg_evt_req | input | EVT_W | Event bits that must be set |
| cfg_evt_forbid | input | EVT_W | Event bits that must be clear |
| cfg_min_lat | input | LAT_W | Minimum latency to keep a sample |
| cfg_ts_en | input | 1 | Timestamp capture enable |
| cfg_pa_en | input | 1 | Physical-address capture enable |
| cfg_user_en | input | 1 | Sample user-level operations |
| cfg_kern_en | input | 1 | Sample kernel-level operations |
| ptr_load | input | 1 | Loads the buffer pointer from ptr_value |
| ptr_value | input | ADDR_W | New buffer pointer |
| buf_limit | input | ADDR_W | Buffer limit address |
| full_clr | input | 1 | Clears the full flag |
| op_valid | input | 1 | An operation issues this cycle |
| op_id | input | ID_W | Issue identifier |
| op_pc | input | ADDR_W | Operation PC |
| op_cls | input | 5 | One-hot operation class |
| op_kernel | input | 1 | Operation runs at kernel level |
| cmp_valid | input | 1 | An operation completes this cycle |
| cmp_id | input | ID_W | Completing identifier |
| cmp_va | input | ADDR_W | Data virtual address |
| cmp_pa | input | ADDR_W | Data physical address |
| cmp_events | input | EVT_W | Event bits of the completed operation |
| cmp_src | input | SRC_W | Data-source code |
| ts_now | input | TS_W | Current timestamp |
| wr_valid | output | 1 | Record beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_last | output | 1 | Final beat of a record |
| buf_full | output | 1 | Sticky buffer-full flag |
| svc_irq | output | 1 | Service interrupt request |
| collisions | output | CNT_W | Count of selections lost to a busy tracker |

## Verification
The bench builds the block with the following parameters:
- `MIN_INTERVAL` = 4, so that clamping a two-operation interval up to four is seen within a few issue cycles.
- `LAT_W` = 4, so that latency saturates at 15 after a short wait.
- `JIT_W` = 3, so that every jittered period must land in an 8-wide window above a base of 8.
- A 32-bit address and a 4-bit identifier, which keep record contents easy to predict.

With these values, the full-buffer path is reached by placing the limit 48 bytes past the pointer. Collisions are counted by leaving one sampled operation uncompleted across several periods.

// File: rtl/samp_pkg.sv
package samp_pkg;
   localparam int CLS_W      = 5;
   localparam int DATA_W     = 64;
   localparam int REC_BEATS  = 4;
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int REC_BYTES  = REC_BEATS * BEAT_BYTES;

   typedef enum logic [1:0] {
      TRK_IDLE,
      TRK_WAIT,
      TRK_WRITE
   } trk_state_e;
endpackage

// File: rtl/samp_interval.sv
module samp_interval #(
   parameter int CNT_W        = 16,
   parameter int MIN_INTERVAL = 256,
   parameter int JIT_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [CNT_W-1:0] cfg_interval,
   input  logic             cfg_jitter,
   output logic             hit
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_INTERVAL);

   logic [CNT_W-1:0] cnt, base, reload;
   logic [15:0]      lfsr;
   logic             fb;

   assign base = (cfg_interval < MIN_V) ? MIN_V : cfg_interval;
   assign fb   = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
   assign hit  = (cnt <= CNT_W'(1));

   generate
      if (JIT_W == 0) begin : g_plain
         assign reload = base;
      end else begin : g_jit
         logic [JIT_W-1:0] jit;
         assign jit    = lfsr[JIT_W-1:0] & {JIT_W{cfg_jitter}};
         assign reload = base ^ CNT_W'(jit);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= MIN_V;
         lfsr <= 16'hACE1;
      end else if (!en) begin
         cnt <= base;
      end else if (step) begin
         if (hit) begin
            cnt  <= reload;
            lfsr <= {lfsr[14:0], fb};
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/samp_filter.sv
module samp_filter #(
   parameter int EVT_W = 16,
   parameter int LAT_W = 12
) (
   input  logic [4:0]       cls,
   input  logic [EVT_W-1:0] events,
   input  logic [LAT_W-1:0] lat,
   input  logic [4:0]       cls_mask,
   input  logic [EVT_W-1:0] evt_req,
   input  logic [EVT_W-1:0] evt_forbid,
   input  logic [LAT_W-1:0] min_lat,
   output logic             pass
);
   logic cls_ok, ev_ok, lat_ok;

   assign cls_ok = (cls_mask == '0) || ((cls & cls_mask) != '0);
   assign ev_ok  = ((events & evt_req) == evt_req) && ((events & evt_forbid) == '0);
   assign lat_ok = (lat >= min_lat);
   assign pass   = cls_ok && ev_ok && lat_ok;
endmodule

// File: rtl/samp_writer.sv
module samp_writer
   import samp_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start,
   input  logic                               set_full,
   input  logic [REC_BEATS-1:0][DATA_W-1:0]   rec_in,
   input  logic                               ptr_load,
   input  logic [ADDR_W-1:0]                  ptr_value,
   input  logic [ADDR_W-1:0]                  limit,
   input  logic                               full_clr,
   input  logic                               wr_ready,
   output logic                               wr_valid,
   output logic [ADDR_W-1:0]                  wr_addr,
   output logic [DATA_W-1:0]                  wr_data,
   output logic                               wr_last,
   output logic                               done,
   output logic                               fits,
   output logic                               full
);
   localparam int BW = $clog2(REC_BEATS);

   logic [REC_BEATS-1:0][DATA_W-1:0] rec_q;
   logic [BW-1:0]                    beat;
   logic [ADDR_W-1:0]                ptr;
   logic [ADDR_W:0]                  end_addr;
   logic                             busy, hs;

   assign end_addr = {1'b0, ptr} + (ADDR_W+1)'(REC_BYTES);
   assign fits     = (end_addr <= {1'b0, limit});
   assign wr_valid = busy;
   assign wr_addr  = ptr;
   assign wr_data  = rec_q[beat];
   assign wr_last  = busy && (beat == BW'(REC_BEATS-1));
   assign hs       = busy && wr_ready;
   assign done     = hs && wr_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         beat  <= '0;
         rec_q <= '0;
         ptr   <= '0;
         full  <= 1'b0;
      end else begin
         if (set_full)      full <= 1'b1;
         else if (full_clr) full <= 1'b0;

         if (ptr_load) ptr <= ptr_value;
         else if (hs)  ptr <= ptr + ADDR_W'(BEAT_BYTES);

         if (start) begin
            busy  <= 1'b1;
            beat  <= '0;
            rec_q <= rec_in;
         end else if (hs) begin
            if (wr_last) busy <= 1'b0;
            else         beat <= beat + BW'(1);
         end
      end
   end
endmodule

// File: rtl/op_sampler.sv
module op_sampler
   import samp_pkg::*;
#(
   parameter int ADDR_W       = 48,
   parameter int ID_W         = 6,
   parameter int EVT_W        = 16,
   parameter int LAT_W        = 12,
   parameter int SRC_W        = 8,
   parameter int TS_W         = 32,
   parameter int CNT_W        = 16,
   parameter int MIN_INTERVAL = 256,
   parameter int JIT_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic [CNT_W-1:0]  cfg_interval,
   input  logic              cfg_jitter,
   input  logic [4:0]        cfg_cls_mask,
   input  logic [EVT_W-1:0]  cfg_evt_req,
   input  logic [EVT_W-1:0]  cfg_evt_forbid,
   input  logic [LAT_W-1:0]  cfg_min_lat,
   input  logic              cfg_ts_en,
   input  logic              cfg_pa_en,
   input  logic              cfg_user_en,
   input  logic              cfg_kern_en,
   input  logic              ptr_load,
   input  logic [ADDR_W-1:0] ptr_value,
   input  logic [ADDR_W-1:0] buf_limit,
   input  logic              full_clr,
   input  logic              op_valid,
   input  logic [ID_W-1:0]   op_id,
   input  logic [ADDR_W-1:0] op_pc,
   input  logic [4:0]        op_cls,
   input  logic              op_kernel,
   input  logic              cmp_valid,
   input  logic [ID_W-1:0]   cmp_id,
   input  logic [ADDR_W-1:0] cmp_va,
   input  logic [ADDR_W-1:0] cmp_pa,
   input  logic [EVT_W-1:0]  cmp_events,
   input  logic [SRC_W-1:0]  cmp_src,
   input  logic [TS_W-1:0]   ts_now,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [63:0]       wr_data,
   output logic              wr_last,
   output logic              buf_full,
   output logic              svc_irq,
   output logic [CNT_W-1:0]  collisions
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 8..64");
      end
      if (LAT_W < 2 || LAT_W > 16) begin : g_bad_lat
         $error("LAT_W must lie in 2..16");
      end
      if (SRC_W > 8 || TS_W > 32) begin : g_bad_fields
         $error("source or timestamp field too wide for the record");
      end
      if (JIT_W > 16 || JIT_W >= CNT_W || MIN_INTERVAL < 2) begin : g_bad_interval
         $error("interval parameters inconsistent");
      end
   endgenerate

   localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

   trk_state_e                   state;
   logic [ID_W-1:0]              trk_id;
   logic [ADDR_W-1:0]            trk_pc;
   logic [4:0]                   trk_cls;
   logic [LAT_W-1:0]             lat;
   logic                         hit, sel, lvl_ok, cmp_hit, pass;
   logic                         accept, set_full, fits, full, wdone;
   logic [REC_BEATS-1:0][DATA_W-1:0] rec;
   logic [TS_W-1:0]              ts_sel;

   samp_interval #(.CNT_W(CNT_W), .MIN_INTERVAL(MIN_INTERVAL), .JIT_W(JIT_W)) u_int (
      .clk(clk), .rst_n(rst_n), .en(samp_en), .step(op_valid),
      .cfg_interval(cfg_interval), .cfg_jitter(cfg_jitter), .hit(hit));

   samp_filter #(.EVT_W(EVT_W), .LAT_W(LAT_W)) u_flt (
      .cls(trk_cls), .events(cmp_events), .lat(lat),
      .cls_mask(cfg_cls_mask), .evt_req(cfg_evt_req), .evt_forbid(cfg_evt_forbid),
      .min_lat(cfg_min_lat), .pass(pass));

   assign sel      = op_valid && samp_en && hit;
   assign lvl_ok   = op_kernel ? cfg_kern_en : cfg_user_en;
   assign cmp_hit  = (state == TRK_WAIT) && cmp_valid && (cmp_id == trk_id);
   assign accept   = cmp_hit && pass && !full && fits;
   assign set_full = cmp_hit && pass && !full && !fits;
   assign ts_sel   = cfg_ts_en ? ts_now : '0;

   assign rec[0] = DATA_W'(trk_pc);
   assign rec[1] = DATA_W'(cmp_va);
   assign rec[2] = cfg_pa_en ? DATA_W'(cmp_pa) : '0;
   assign rec[3] = {32'(ts_sel), 8'(cmp_src), 16'(lat), 3'b000, trk_cls};

   samp_writer #(.ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .start(accept), .set_full(set_full), .rec_in(rec),
      .ptr_load(ptr_load), .ptr_value(ptr_value), .limit(buf_limit), .full_clr(full_clr),
      .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_last(wr_last), .done(wdone), .fits(fits), .full(full));

   assign buf_full = full;
   assign svc_irq  = full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= TRK_IDLE;
         trk_id     <= '0;
         trk_pc     <= '0;
         trk_cls    <= '0;
         lat        <= '0;
         collisions <= '0;
      end else begin
         if (sel && lvl_ok && state != TRK_IDLE)
            collisions <= collisions + CNT_W'(1);
         case (state)
            TRK_IDLE: if (sel && lvl_ok) begin
               state   <= TRK_WAIT;
               trk_id  <= op_id;
               trk_pc  <= op_pc;
               trk_cls <= op_cls;
               lat     <= '0;
            end
            TRK_WAIT: begin
               if (cmp_hit)              state <= accept ? TRK_WRITE : TRK_IDLE;
               else if (lat != LAT_MAX)  lat   <= lat + LAT_W'(1);
            end
            TRK_WRITE: if (wdone) state <= TRK_IDLE;
            default: state <= TRK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/samp_checker.sv
module samp_checker #(
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              samp_en,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [63:0]       wr_data,
   input logic              wr_last,
   input logic              buf_full,
   input logic              full_clr,
   input logic [CNT_W-1:0]  collisions
);
   // R11
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last)));

   // R3
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && !wr_last) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(8)));

   // R3
   rec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_last) |=> !wr_valid);

   // R10
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !full_clr) |=> buf_full);

   // R10
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> !buf_full);

   // R9
   coll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (collisions == $past(collisions)) || (collisions == $past(collisions) + CNT_W'(1)));

   // R9
   coll_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (collisions != $past(collisions)) |-> $past(op_valid && samp_en));
endmodule

bind op_sampler samp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .samp_en(samp_en),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_last(wr_last), .buf_full(buf_full), .full_clr(full_clr), .collisions(collisions));

// File: tb/sim_op_sampler.sv
`timescale 1ns/1ps
module sim_op_sampler;
   localparam int AW = 32, IW = 4, EW = 8, LW = 4, SW = 8, TW = 32, CW = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, samp_en, cfg_jitter, cfg_ts_en, cfg_pa_en, cfg_user_en, cfg_kern_en;
   logic [CW-1:0] cfg_interval;
   logic [4:0] cfg_cls_mask;
   logic [EW-1:0] cfg_evt_req, cfg_evt_forbid;
   logic [LW-1:0] cfg_min_lat;
   logic ptr_load, full_clr;
   logic [AW-1:0] ptr_value, buf_limit;
   logic op_valid, op_kernel, cmp_valid;
   logic [IW-1:0] op_id, cmp_id;
   logic [AW-1:0] op_pc, cmp_va, cmp_pa;
   logic [4:0] op_cls;
   logic [EW-1:0] cmp_events;
   logic [SW-1:0] cmp_src;
   logic [TW-1:0] ts_now;
   logic wr_valid, wr_ready, wr_last, buf_full, svc_irq;
   logic [AW-1:0] wr_addr;
   logic [63:0] wr_data;
   logic [CW-1:0] collisions;

   op_sampler #(.ADDR_W(AW), .ID_W(IW), .EVT_W(EW), .LAT_W(LW), .SRC_W(SW), .TS_W(TW),
                .CNT_W(CW), .MIN_INTERVAL(4), .JIT_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .cfg_interval(cfg_interval),
      .cfg_jitter(cfg_jitter), .cfg_cls_mask(cfg_cls_mask), .cfg_evt_req(cfg_evt_req),
      .cfg_evt_forbid(cfg_evt_forbid), .cfg_min_lat(cfg_min_lat), .cfg_ts_en(cfg_ts_en),
      .cfg_pa_en(cfg_pa_en), .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en),
      .ptr_load(ptr_load), .ptr_value(ptr_value), .buf_limit(buf_limit), .full_clr(full_clr),
      .op_valid(op_valid), .op_id(op_id), .op_pc(op_pc), .op_cls(op_cls), .op_kernel(op_kernel),
      .cmp_valid(cmp_valid), .cmp_id(cmp_id), .cmp_va(cmp_va), .cmp_pa(cmp_pa),
      .cmp_events(cmp_events), .cmp_src(cmp_src), .ts_now(ts_now),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_last(wr_last), .buf_full(buf_full), .svc_irq(svc_irq), .collisions(collisions));

   typedef struct {
      logic [AW-1:0] a;
      logic [63:0]   d;
      logic          l;
      string         tag;
   } beat_t;

   beat_t sbq[$];
   int errors = 0, checks = 0;
   int period = 5;
   int rcnt = 0;
   bit stall = 0, finished = 0;
   logic [AW-1:0] exp_ptr;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected beats as the design emits them
   initial begin
      beat_t e;
      forever begin
         @(negedge clk);
         if (rst_n && wr_valid && wr_ready) begin
            if (sbq.size() == 0) chk(0, "R3 unexpected beat", 64'(wr_addr), 64'hDEAD);
            else begin
               e = sbq.pop_front();
               chk(wr_addr == e.a, {e.tag, " addr"}, 64'(wr_addr), 64'(e.a));
               chk(wr_data == e.d && wr_last == e.l, {e.tag, " data"}, wr_data, e.d);
            end
         end
      end
   end

   // R11 stimulus: ready drops every third cycle when stall is set
   initial begin
      wr_ready = 1'b1;
      forever begin
         @(posedge clk); #1;
         rcnt++;
         wr_ready = !stall || (rcnt % 3 != 0);
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      repeat (n) cyc();
   endtask

   task automatic put_op(input logic [IW-1:0] id, input logic [AW-1:0] pc, input logic [4:0] cls, input logic kern);
      op_valid = 1; op_id = id; op_pc = pc; op_cls = cls; op_kernel = kern;
      cyc();
      op_valid = 0;
   endtask

   task automatic put_cmp(input logic [IW-1:0] id, input logic [AW-1:0] va, input logic [AW-1:0] pa,
                          input logic [EW-1:0] ev, input logic [SW-1:0] src, input logic [TW-1:0] ts);
      cmp_valid = 1; cmp_id = id; cmp_va = va; cmp_pa = pa; cmp_events = ev; cmp_src = src; ts_now = ts;
      cyc();
      cmp_valid = 0;
   endtask

   task automatic restart();
      samp_en = 0;
      cyc();
      samp_en = 1;
   endtask

   // driver side of the scoreboard: push the four expected beats (R3, R4)
   task automatic expect_rec(input logic [AW-1:0] pc, input logic [AW-1:0] va, input logic [AW-1:0] pa,
                             input logic [TW-1:0] ts, input logic [SW-1:0] src, input int lat,
                             input logic [4:0] cls, input string tag);
      logic [63:0] b3;
      b3 = {cfg_ts_en ? 32'(ts) : 32'h0, 8'(src), 16'(lat), 3'b000, cls};
      sbq.push_back('{exp_ptr,      64'(pc), 1'b0, tag});
      sbq.push_back('{exp_ptr + 8,  64'(va), 1'b0, tag});
      sbq.push_back('{exp_ptr + 16, cfg_pa_en ? 64'(pa) : 64'h0, 1'b0, tag});
      sbq.push_back('{exp_ptr + 24, b3, 1'b1, tag});
      exp_ptr = exp_ptr + 32;
   endtask

   task automatic sample(input logic kern, input logic [4:0] cls, input logic [AW-1:0] pc,
                         input logic [IW-1:0] id, input int gap, input bit decoy,
                         input logic [EW-1:0] ev, input bit want, input string tag);
      int lat;
      restart();
      repeat (period - 1) put_op(4'hF, '0, 5'b00001, 1'b0);
      put_op(id, pc, cls, kern);
      idle(gap);
      if (decoy) put_cmp(id ^ 4'h1, 32'hBAD0, 32'hBAD1, ev, 8'h77, 32'h99);
      lat = gap + int'(decoy);
      if (lat > 15) lat = 15;
      if (want) expect_rec(pc, pc + 32'hA000, pc + 32'hB000, 32'h1000 + pc, 8'h5A, lat, cls, tag);
      put_cmp(id, pc + 32'hA000, pc + 32'hB000, ev, 8'h5A, 32'h1000 + pc);
   endtask

   task automatic drain(input string tag);
      idle(14);
      chk(sbq.size() == 0, tag, 64'(sbq.size()), 64'h0);
   endtask

   initial begin
      int c0, n;
      rst_n = 0; samp_en = 0; cfg_interval = 5; cfg_jitter = 0; cfg_cls_mask = 0;
      cfg_evt_req = 0; cfg_evt_forbid = 0; cfg_min_lat = 0; cfg_ts_en = 1; cfg_pa_en = 1;
      cfg_user_en = 1; cfg_kern_en = 1; ptr_load = 0; ptr_value = 0; buf_limit = 32'h10000;
      full_clr = 0; op_valid = 0; op_id = 0; op_pc = 0; op_cls = 0; op_kernel = 0;
      cmp_valid = 0; cmp_id = 0; cmp_va = 0; cmp_pa = 0; cmp_events = 0; cmp_src = 0; ts_now = 0;
      idle(3);
      rst_n = 1;
      cyc();
      chk(!wr_valid, "R3 reset wr_valid", 64'(wr_valid), 0);
      chk(!buf_full && !svc_irq, "R10 reset full", 64'({buf_full, svc_irq}), 0);
      chk(collisions == 0, "R9 reset collisions", 64'(collisions), 0);

      ptr_load = 1; ptr_value = 32'h100; cyc(); ptr_load = 0;
      exp_ptr = 32'h100;

      // R1 R3 R8 basic record, latency 3
      sample(0, 5'b00010, 32'h1234, 4'h2, 3, 0, 8'h00, 1, "R1 R3 R8 basic");
      drain("R1 basic drained");
      // R11 stalled write port, latency 0
      stall = 1;
      sample(1, 5'b00100, 32'h2000, 4'h3, 0, 0, 8'h00, 1, "R11 stalled");
      drain("R11 stalled drained");
      stall = 0;
      // R4 capture disabled, R12 foreign completion ignored
      cfg_ts_en = 0; cfg_pa_en = 0;
      sample(0, 5'b01000, 32'h3000, 4'h4, 2, 1, 8'h00, 1, "R4 R12 zeroed fields");
      drain("R12 drained");
      cfg_ts_en = 1; cfg_pa_en = 1;
      // R6 class filter (mask = load)
      cfg_cls_mask = 5'b00010;
      sample(0, 5'b00100, 32'h4000, 4'h5, 1, 0, 8'h00, 0, "R6 store filtered");
      drain("R6 store filtered");
      sample(0, 5'b00010, 32'h4100, 4'h6, 1, 0, 8'h00, 1, "R6 load kept");
      drain("R6 load kept");
      cfg_cls_mask = 0;
      // R7 required / forbidden events
      cfg_evt_req = 8'h03; cfg_evt_forbid = 8'h10;
      sample(0, 5'b00001, 32'h5000, 4'h7, 1, 0, 8'h01, 0, "R7 missing required");
      drain("R7 missing required");
      sample(0, 5'b00001, 32'h5100, 4'h8, 1, 0, 8'h13, 0, "R7 forbidden set");
      drain("R7 forbidden set");
      sample(0, 5'b00001, 32'h5200, 4'h9, 1, 0, 8'h07, 1, "R7 kept");
      drain("R7 kept");
      cfg_evt_req = 0; cfg_evt_forbid = 0;
      // R8 minimum latency and saturation
      cfg_min_lat = 5;
      sample(0, 5'b10000, 32'h6000, 4'hA, 2, 0, 8'h00, 0, "R8 too fast");
      drain("R8 too fast");
      sample(0, 5'b10000, 32'h6100, 4'hB, 6, 0, 8'h00, 1, "R8 slow kept");
      drain("R8 slow kept");
      cfg_min_lat = 0;
      sample(0, 5'b10000, 32'h6200, 4'hC, 20, 0, 8'h00, 1, "R8 saturated");
      drain("R8 saturated");
      // R5 level enables
      cfg_kern_en = 0;
      sample(1, 5'b00010, 32'h7000, 4'hD, 1, 0, 8'h00, 0, "R5 kernel off");
      drain("R5 kernel off");
      sample(0, 5'b00010, 32'h7100, 4'hE, 1, 0, 8'h00, 1, "R5 user on");
      drain("R5 user on");
      cfg_kern_en = 1; cfg_user_en = 0;
      sample(0, 5'b00010, 32'h7200, 4'h1, 1, 0, 8'h00, 0, "R5 user off");
      drain("R5 user off");
      sample(1, 5'b00010, 32'h7300, 4'h2, 1, 0, 8'h00, 1, "R5 kernel on");
      drain("R5 kernel on");
      cfg_user_en = 1;

      // R2 R9 jitter window measured through collisions, tracker held busy
      cfg_interval = 8;
      restart();
      cfg_jitter = 1;
      repeat (7) put_op(4'hF, '0, 5'b00001, 1'b0);
      put_op(4'h3, 32'h8000, 5'b00010, 1'b0);
      c0 = int'(collisions);
      for (int k = 0; k < 4; k++) begin
         n = 0;
         do begin
            put_op(4'hF, '0, 5'b00001, 1'b0);
            n++;
         end while (int'(collisions) == c0 + k && n < 40);
         chk(n >= 8 && n <= 15, "R2 jittered period", 64'(n), 64'd8);
         chk(int'(collisions) == c0 + k + 1, "R9 collision step", 64'(collisions), 64'(c0 + k + 1));
      end
      // R1 clamp to MIN_INTERVAL
      cfg_jitter = 0; cfg_interval = 2;
      restart();
      for (int k = 0; k < 3; k++) begin
         n = 0;
         do begin
            put_op(4'hF, '0, 5'b00001, 1'b0);
            n++;
         end while (int'(collisions) == c0 + 4 + k && n < 40);
         chk(n == 4, "R1 clamped period", 64'(n), 64'd4);
      end
      chk(int'(collisions) == c0 + 7, "R9 collision total", 64'(collisions), 64'(c0 + 7));
      expect_rec(32'h8000, 32'h8A00, 32'h8B00, 32'h42, 8'h5A, 15, 5'b00010, "R9 held sample");
      put_cmp(4'h3, 32'h8A00, 32'h8B00, 8'h00, 8'h5A, 32'h42);
      drain("R9 held sample drained");
      cfg_interval = 5;

      // R10 buffer limit
      buf_limit = exp_ptr + 48;
      sample(0, 5'b00001, 32'h9000, 4'h4, 1, 0, 8'h00, 1, "R10 last fit");
      drain("R10 last fit");
      sample(0, 5'b00001, 32'h9100, 4'h5, 1, 0, 8'h00, 0, "R10 overflow");
      chk(buf_full && svc_irq, "R10 full raised", 64'({buf_full, svc_irq}), 64'h3);
      drain("R10 overflow not written");
      buf_limit = 32'h10000;
      sample(0, 5'b00001, 32'h9200, 4'h6, 1, 0, 8'h00, 0, "R10 dropped while full");
      drain("R10 dropped while full");
      chk(buf_full, "R10 full sticky", 64'(buf_full), 64'h1);
      full_clr = 1; cyc(); full_clr = 0;
      chk(!buf_full && !svc_irq, "R10 full cleared", 64'({buf_full, svc_irq}), 0);
      sample(0, 5'b00001, 32'h9300, 4'h7, 1, 0, 8'h00, 1, "R10 pointer unchanged");
      drain("R10 resumed");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule